// File: doc/BRIEF.md
# Invariant Time Stamp Counter

This block keeps a 64-bit count of ticks since reset for a processor-like subsystem. A mode input selects the tick source. In legacy mode the count advances on every core clock cycle that the core clock-enable allows, so any change of core frequency changes the tick rate. In invariant mode the count advances once per pulse of a reference tick that comes from another clock domain. Each tick then lasts the same time, whatever the core is doing.

A small decoder watches a two-byte opcode presented with a valid strobe. When it sees the timestamp read opcode, it captures the whole count in one cycle. It returns the upper half through the high destination result and the lower half through the low destination result. In 64-bit operating mode the upper 32 bits of both destinations are written as zero. Otherwise those upper bits keep the current contents of the destination registers, which the caller supplies.

A privileged control bit can forbid reads from user level. Such a read then raises an illegal-instruction fault and returns no result. A privileged write port loads the count directly. A registered capability flag reports whether invariant mode is active.

Top module: `tsc_top`

## Requirements
- R1: After reset the count is zero, so a read issued while the count has not advanced returns zero in both halves; all outputs are zero during reset.
- R2: In legacy mode (invariantMode = 0) the count increases by one at each clock edge where coreClkEn is 1 and stays unchanged where it is 0.
- R3: In invariant mode the count increases by one for each rising edge of refTick, which passes through a two-flop synchroniser and a rising-edge detector, so the increment happens at the third clock edge after refTick is first sampled high; coreClkEn has no effect in this mode.
- R4: A read is opValid = 1 with opByte0 = 0x0F and opByte1 = 0x31; at the next edge rdValid pulses for one cycle, rdHigh[31:0] holds count bits 63:32 and rdLow[31:0] holds count bits 31:0, both taken from the same count value (the value before that edge), and the results hold until the next read.
- R5: When cpuMode64 = 1 the read writes zero to rdHigh[63:32] and rdLow[63:32]; when 0 those bits take oldHigh[63:32] and oldLow[63:32].
- R6: When userAccessDis = 1 and userLevel = 1, a read opcode instead pulses faultIllegal for one cycle; rdValid stays 0 and the result outputs do not change.
- R7: A cycle with opValid = 0, or with any other opcode byte pair, produces neither rdValid nor faultIllegal and leaves the results unchanged.
- R8: wrEn = 1 loads wrData into the count at that edge, taking priority over an increment in the same cycle.
- R9: The count wraps from all ones to zero with no flag.
- R10: invariantCap equals invariantMode as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| invariantMode | input | 1 | 1 selects reference-tick counting, 0 selects core-cycle counting |
| coreClkEn | input | 1 | Core clock enable, used in legacy mode |
| refTick | input | 1 | Asynchronous reference tick; each rising edge is one tick |
| opValid | input | 1 | Opcode bytes are valid this cycle |
| opByte0 | input | 8 | First opcode byte |
| opByte1 | input | 8 | Second opcode byte |
| cpuMode64 | input | 1 | 64-bit operating mode |
| userLevel | input | 1 | The issuing code runs at user level |
| userAccessDis | input | 1 | Privileged bit that forbids user-level reads |
| oldHigh | input | 64 | Current contents of the high destination register |
| oldLow | input | 64 | Current contents of the low destination register |
| wrEn | input | 1 | Privileged load of the count |
| wrData | input | 64 | Value to load |
| rdValid | output | 1 | One-cycle pulse: read results updated |
| rdHigh | output | 64 | High destination result |
| rdLow | output | 64 | Low destination result |
| faultIllegal | output | 1 | One-cycle illegal-instruction fault |
| invariantCap | output | 1 | Capability flag: invariant mode active |

## Verification
The checker assumes that the inputs settle well away from the clock edge and that wrEn and opValid are held low while reset is asserted. It also assumes that refTick may change at any cycle but always stays at a level for at least one clock. The bench drives every input on the falling edge. It toggles refTick only from level to level, so the synchroniser never sees a pulse narrower than a cycle. A behavioural model tracks the count, the synchroniser delay and the destination rules, and each output is compared against it on every cycle.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic load;      // take the write data
    logic inc;       // advance by one
    logic capture;   // latch a read result
  } tscStrobes_t;
endpackage

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] OP_FIRST = 8'h0F,
  parameter logic [7:0] OP_SECOND = 8'h31
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        invariantMode,
  input  logic        coreClkEn,
  input  logic        refTick,
  input  logic        opValid,
  input  logic [7:0]  opByte0,
  input  logic [7:0]  opByte1,
  input  logic        userLevel,
  input  logic        userAccessDis,
  input  logic        wrEn,
  output tscStrobes_t strobes,
  output logic        faultIllegal,
  output logic        invariantCap
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic tickPrev;
  logic tickPulse;
  logic isReadOp;
  logic blocked;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= refTick;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[gi] <= 1'b0;
          else       syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickPrev <= 1'b0;
    else       tickPrev <= syncChain[SYNC_STAGES-1];
  end

  assign tickPulse = syncChain[SYNC_STAGES-1] & ~tickPrev;
  assign isReadOp  = opValid && (opByte0 == OP_FIRST) && (opByte1 == OP_SECOND);
  assign blocked   = userAccessDis && userLevel;

  always_comb begin
    strobes.load    = wrEn;
    strobes.inc     = invariantMode ? tickPulse : coreClkEn;
    strobes.capture = isReadOp && !blocked;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultIllegal <= 1'b0;
      invariantCap <= 1'b0;
    end else begin
      faultIllegal <= isReadOp && blocked;
      invariantCap <= invariantMode;
    end
  end
endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
#(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tscStrobes_t       strobes,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              cpuMode64,
  input  logic [CNT_W-1:0]  oldHigh,
  input  logic [CNT_W-1:0]  oldLow,
  output logic [CNT_W-1:0]  count,
  output logic              rdValid,
  output logic [CNT_W-1:0]  rdHigh,
  output logic [CNT_W-1:0]  rdLow
);
  logic [HALF_W-1:0] upperHigh;
  logic [HALF_W-1:0] upperLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (strobes.load)  count <= wrData;
    else if (strobes.inc)   count <= count + 1'b1;
  end

  assign upperHigh = cpuMode64 ? '0 : oldHigh[CNT_W-1:HALF_W];
  assign upperLow  = cpuMode64 ? '0 : oldLow[CNT_W-1:HALF_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdHigh  <= '0;
      rdLow   <= '0;
    end else begin
      rdValid <= strobes.capture;
      if (strobes.capture) begin
        rdHigh <= {upperHigh, count[CNT_W-1:HALF_W]};
        rdLow  <= {upperLow,  count[HALF_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/tsc_top.sv
module tsc_top
  import tsc_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              invariantMode,
  input  logic              coreClkEn,
  input  logic              refTick,
  input  logic              opValid,
  input  logic [7:0]        opByte0,
  input  logic [7:0]        opByte1,
  input  logic              cpuMode64,
  input  logic              userLevel,
  input  logic              userAccessDis,
  input  logic [CNT_W-1:0]  oldHigh,
  input  logic [CNT_W-1:0]  oldLow,
  input  logic              wrEn,
  input  logic [CNT_W-1:0]  wrData,
  output logic              rdValid,
  output logic [CNT_W-1:0]  rdHigh,
  output logic [CNT_W-1:0]  rdLow,
  output logic              faultIllegal,
  output logic              invariantCap
);
  tscStrobes_t strobes;
  logic [CNT_W-1:0] count;

  tsc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .invariantMode(invariantMode), .coreClkEn(coreClkEn),
    .refTick(refTick), .opValid(opValid), .opByte0(opByte0), .opByte1(opByte1),
    .userLevel(userLevel), .userAccessDis(userAccessDis), .wrEn(wrEn),
    .strobes(strobes), .faultIllegal(faultIllegal), .invariantCap(invariantCap)
  );

  tsc_datapath #(.HALF_W(HALF_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .cpuMode64(cpuMode64), .oldHigh(oldHigh), .oldLow(oldLow),
    .count(count), .rdValid(rdValid), .rdHigh(rdHigh), .rdLow(rdLow)
  );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             invariantMode,
  input logic             coreClkEn,
  input logic             opValid,
  input logic             cpuMode64,
  input logic             wrEn,
  input logic [CNT_W-1:0] wrData,
  input logic [CNT_W-1:0] count,
  input logic             rdValid,
  input logic [CNT_W-1:0] rdHigh,
  input logic [CNT_W-1:0] rdLow,
  input logic             faultIllegal,
  input logic             invariantCap
);
  localparam int HALF_W = CNT_W / 2;
  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R6: a fault and a result never coincide
  a_r6_fault_excludes_result: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdValid, faultIllegal}));

  // R7: no opcode, no response
  a_r7_idle_no_response: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !$past(opValid) |-> !rdValid && !faultIllegal);

  // R5: 64-bit mode zeroes the upper destination bits
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && rdValid && $past(cpuMode64) |->
      rdHigh[CNT_W-1:HALF_W] == '0 && rdLow[CNT_W-1:HALF_W] == '0);

  // R8: load wins over increment
  a_r8_load_priority: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(wrEn) |-> count == $past(wrData));

  // R2 and R9: legacy increment, wrapping modulo 2^CNT_W
  a_r2_legacy_step: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(!wrEn && !invariantMode && coreClkEn) |->
      count == $past(count) + 1'b1);

  // R2: legacy hold when the core clock is gated
  a_r2_legacy_hold: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(!wrEn && !invariantMode && !coreClkEn) |-> $stable(count));

  // R10: capability flag follows the mode one cycle later
  a_r10_cap_follows: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> invariantCap == $past(invariantMode));
endmodule

bind tsc_top tsc_checker #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .invariantMode(invariantMode), .coreClkEn(coreClkEn),
  .opValid(opValid), .cpuMode64(cpuMode64), .wrEn(wrEn), .wrData(wrData),
  .count(count), .rdValid(rdValid), .rdHigh(rdHigh), .rdLow(rdLow),
  .faultIllegal(faultIllegal), .invariantCap(invariantCap)
);

// File: tb/test_tsc_top.sv
module test_tsc_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic invariantMode = 0, coreClkEn = 0, refTick = 0, opValid = 0;
  logic [7:0] opByte0 = 0, opByte1 = 0;
  logic cpuMode64 = 1, userLevel = 0, userAccessDis = 0, wrEn = 0;
  logic [63:0] oldHigh = 0, oldLow = 0, wrData = 0;
  logic rdValid, faultIllegal, invariantCap;
  logic [63:0] rdHigh, rdLow;

  int nCmp = 0, nBad = 0;
  bit done = 0;

  // reference model state
  logic [63:0] mCount = 0, mHigh = 0, mLow = 0;
  logic mValid = 0, mFault = 0, mCap = 0;
  logic [2:0] mSync = 0; // two sync stages and the edge-detect history

  always #2 clk = ~clk; // 250 MHz

  tsc_top i_tsc_top (
    .clk(clk), .rstN(rstN), .invariantMode(invariantMode), .coreClkEn(coreClkEn),
    .refTick(refTick), .opValid(opValid), .opByte0(opByte0), .opByte1(opByte1),
    .cpuMode64(cpuMode64), .userLevel(userLevel), .userAccessDis(userAccessDis),
    .oldHigh(oldHigh), .oldLow(oldLow), .wrEn(wrEn), .wrData(wrData),
    .rdValid(rdValid), .rdHigh(rdHigh), .rdLow(rdLow),
    .faultIllegal(faultIllegal), .invariantCap(invariantCap)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCount = 0; mHigh = 0; mLow = 0; mValid = 0; mFault = 0; mCap = 0; mSync = 0;
    end else begin
      bit pulse, isRd, deny;
      pulse = mSync[1] && !mSync[2];
      isRd  = opValid && opByte0 == 8'h0F && opByte1 == 8'h31;
      deny  = userAccessDis && userLevel;
      mValid = isRd && !deny;
      mFault = isRd && deny;
      if (mValid) begin
        mHigh = {cpuMode64 ? 32'h0 : oldHigh[63:32], mCount[63:32]};
        mLow  = {cpuMode64 ? 32'h0 : oldLow[63:32],  mCount[31:0]};
      end
      if (wrEn) mCount = wrData;
      else if (invariantMode ? pulse : coreClkEn) mCount = mCount + 1;
      mSync = {mSync[1], mSync[0], refTick};
      mCap = invariantMode;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R4 rdValid", rdValid, mValid);
    chk("R4 rdHigh", rdHigh, mHigh);
    chk("R5 rdLow", rdLow, mLow);
    chk("R6 faultIllegal", faultIllegal, mFault);
    chk("R10 invariantCap", invariantCap, mCap);
  endtask

  task automatic step();
    @(negedge clk);
    compareAll();
  endtask

  task automatic setRead(bit on);
    opValid = on; opByte0 = on ? 8'h0F : 8'h00; opByte1 = on ? 8'h31 : 8'h00;
  endtask

  initial begin
    #20000000;
    nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero in reset
    chk("R1 reset rdHigh", rdHigh, 0);
    chk("R1 reset flags", {rdValid, faultIllegal, invariantCap}, 0);
    rstN = 1;
    // R1: read at once returns zero
    setRead(1); step(); setRead(0);
    chk("R1 first read", rdLow, 0);
    // R2: legacy counting, five enabled cycles
    coreClkEn = 1; repeat (5) step(); coreClkEn = 0;
    step(); step();
    setRead(1); step(); setRead(0);
    chk("R2 five ticks", rdLow, 5);
    // R8: load wins over increment
    wrEn = 1; wrData = 64'h1234_5678_9ABC_DEF0; coreClkEn = 1; step();
    wrEn = 0; coreClkEn = 0; setRead(1); step(); setRead(0);
    chk("R8 load priority high", rdHigh, 64'h1234_5678);
    chk("R8 load priority low", rdLow, 64'h9ABC_DEF0);
    // R9: wrap to zero
    wrEn = 1; wrData = '1; step(); wrEn = 0;
    coreClkEn = 1; step(); coreClkEn = 0;
    setRead(1); step(); setRead(0);
    chk("R9 wrap", {rdHigh[31:0], rdLow[31:0]}, 0);
    // R5: 32-bit mode keeps upper destination bits
    cpuMode64 = 0; oldHigh = 64'hAAAA_BBBB_0000_0000; oldLow = 64'hCCCC_DDDD_0000_0000;
    setRead(1); step(); setRead(0);
    chk("R5 keep upper high", rdHigh[63:32], 64'hAAAA_BBBB);
    chk("R5 keep upper low", rdLow[63:32], 64'hCCCC_DDDD);
    cpuMode64 = 1;
    // R6: user read when disabled faults, result unchanged
    userAccessDis = 1; userLevel = 1; setRead(1); step(); setRead(0);
    chk("R6 fault raised", {faultIllegal, rdValid}, 2'b10);
    chk("R6 result kept", rdHigh, 64'hAAAA_BBBB_0000_0000);
    userLevel = 0;
    // R7: wrong opcode ignored
    opValid = 1; opByte0 = 8'h0F; opByte1 = 8'h32; step(); opValid = 0;
    chk("R7 ignored", {faultIllegal, rdValid}, 0);
    userAccessDis = 0;
    // R3: invariant mode, coreClkEn ignored, one refTick edge
    wrEn = 1; wrData = 0; step(); wrEn = 0;
    invariantMode = 1; coreClkEn = 1;
    refTick = 1; step(); step(); step(); step(); refTick = 0;
    setRead(1); step(); setRead(0);
    chk("R3 one tick", rdLow, 1);
    chk("R10 cap on", invariantCap, 1);
    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      invariantMode = ($urandom % 200) == 0 ? ~invariantMode : invariantMode;
      coreClkEn = $urandom % 2;
      refTick = ($urandom % 4) == 0 ? ~refTick : refTick;
      case ($urandom % 6)
        0, 1: setRead(1);
        2: begin opValid = 1; opByte0 = $urandom; opByte1 = $urandom; end
        default: setRead(0);
      endcase
      cpuMode64 = $urandom % 2;
      userLevel = $urandom % 2;
      userAccessDis = ($urandom % 4) == 0;
      oldHigh = {$urandom, $urandom}; oldLow = {$urandom, $urandom};
      wrEn = ($urandom % 50) == 0;
      wrData = ($urandom % 2) ? 64'hFFFF_FFFF_FFFF_FFF0 + ($urandom % 16) : {$urandom, $urandom};
      step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule